// File: doc/BRIEF.md
# Two-Read One-Write General Register Bank

This block is the architectural register storage of a simple processor core. It holds a set of general registers and serves two operand reads and one result write in every clock cycle. The two reads are combinational: each read data output follows its index and the stored contents with no clock involved.

A write is captured on the falling edge of the clock, and only when the write enable is high. The decode and execute logic can therefore present a result during the first half of a cycle. The new value then appears on both read ports for the second half, before the next rising edge. Entry zero is a constant zero source. It can be named as a write destination, but nothing is stored there. An asynchronous active-low reset clears every entry. Its release is expected to be synchronized outside the block.

Top module: `gprf_bank_2r1w`

## Requirements
- R1: The bank holds 32 entries of 32 bits by default, and each of the entries 1 to 31 keeps its own value independently of the others.
- R2: Read index 0 returns all zeros on either read port at all times.
- R3: When wr_en is high at a falling clock edge and wr_idx is not 0, the entry named by wr_idx takes wr_data at that edge. The new value is visible on any read port whose index equals wr_idx from just after that edge.
- R4: When wr_en is low at a falling edge, no entry changes.
- R5: The two read ports are independent and combinational: changing rd_a_idx or rd_b_idx without a clock edge changes the matching data output to the addressed entry, and neither port affects the other.
- R6: While rst_n is low, every entry reads as zero and writes are ignored. This holds immediately, without a clock edge.
- R7: A write to index 0 (wr_en high, wr_idx 0) is accepted and has no visible effect: index 0 still reads zero and no other entry changes.
- R8: When a read index equals the write index during a cycle with wr_en high, the port shows the old contents until the falling edge and the new data after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes occur on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset that clears all entries |
| wr_en | input | 1 | Write enable, sampled at the falling edge |
| wr_idx | input | 5 | Index of the entry to write |
| wr_data | input | 32 | Data to write |
| rd_a_idx | input | 5 | Read port A index |
| rd_a_data | output | 32 | Read port A data (combinational) |
| rd_b_idx | input | 5 | Read port B index |
| rd_b_data | output | 32 | Read port B data (combinational) |

## Verification
Reads carry no latency, so a read result is due as soon as its index settles. A write result is due half a cycle after the inputs are applied, at the falling edge. Each bench cycle drives its inputs just after the rising edge. It checks the old contents before the falling edge and the written contents after it. It then moves both read indices with no edge in between and checks again. The bound properties sample at the rising edge, when the falling-edge write of that cycle is already visible on the reads.

// File: rtl/gprf_pkg.sv
package gprf_pkg;
  // Default geometry of the register bank
  localparam int unsigned GPRF_REGS_DEF  = 32;
  localparam int unsigned GPRF_WIDTH_DEF = 32;
  // Number of combinational read ports served by the bank
  localparam int unsigned GPRF_RD_PORTS  = 2;
endpackage

// File: rtl/gprf_wr_decode.sv
// Turns the write request into per-entry enables; entry 0 gets none.
module gprf_wr_decode #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned IDX_W    = 5
) (
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  output logic [NUM_REGS-1:1] row_en
);
  always_comb begin
    row_en = '0;
    for (int unsigned i = 1; i < NUM_REGS; i++) begin
      if (wr_en && (wr_idx == IDX_W'(i))) begin
        row_en[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/gprf_row.sv
// One storage entry, captured on the falling clock edge.
module gprf_row #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] q_r;
  logic [DATA_W-1:0] q_nxt;

  always_comb begin
    q_nxt = wr_en ? wr_data : q_r;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else if (wr_en) begin
      q_r <= q_nxt;
    end
  end

  assign q = q_r;
endmodule

// File: rtl/gprf_rd_mux.sv
// Combinational read selector; index 0 or an index past the bank reads zero.
module gprf_rd_mux #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned IDX_W    = 5
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] rows,
  input  logic [IDX_W-1:0]                idx,
  output logic [DATA_W-1:0]               data
);
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_REGS);

  logic in_range;

  always_comb begin
    in_range = ({1'b0, idx} < LIMIT) && (idx != '0);
    data     = in_range ? rows[idx] : '0;
  end
endmodule

// File: rtl/gprf_bank_2r1w.sv
module gprf_bank_2r1w #(
  parameter int unsigned NUM_REGS = gprf_pkg::GPRF_REGS_DEF,
  parameter int unsigned DATA_W   = gprf_pkg::GPRF_WIDTH_DEF,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data
);
  localparam int unsigned NUM_RD = gprf_pkg::GPRF_RD_PORTS;

  logic [NUM_REGS-1:1]              row_en;
  logic [NUM_REGS-1:0][DATA_W-1:0]  row_q;
  logic [NUM_RD-1:0][IDX_W-1:0]     rd_idx_v;
  logic [NUM_RD-1:0][DATA_W-1:0]    rd_data_v;

  gprf_wr_decode #(
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
  ) wr_dec_i (
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .row_en (row_en)
  );

  // Entry 0 is a constant, not storage
  assign row_q[0] = '0;

  for (genvar r = 1; r < NUM_REGS; r++) begin : g_row
    gprf_row #(
      .DATA_W (DATA_W)
    ) row_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (row_en[r]),
      .wr_data (wr_data),
      .q       (row_q[r])
    );
  end

  assign rd_idx_v[0] = rd_a_idx;
  assign rd_idx_v[1] = rd_b_idx;

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    gprf_rd_mux #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W),
      .IDX_W    (IDX_W)
    ) rd_mux_i (
      .rows (row_q),
      .idx  (rd_idx_v[p]),
      .data (rd_data_v[p])
    );
  end

  assign rd_a_data = rd_data_v[0];
  assign rd_b_data = rd_data_v[1];
endmodule

// File: rtl/gprf_chk.sv
module gprf_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic [IDX_W-1:0]  rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [IDX_W-1:0]  rd_b_idx,
  input logic [DATA_W-1:0] rd_b_data
);
  // R2
  rd_a_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == '0) |-> (rd_a_data == '0));

  // R2
  rd_b_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_idx == '0) |-> (rd_b_data == '0));

  // R3
  wr_a_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx != '0) && (rd_a_idx == wr_idx)) |-> (rd_a_data == wr_data));

  // R3
  wr_b_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx != '0) && (rd_b_idx == wr_idx)) |-> (rd_b_data == wr_data));

  // R4
  idle_a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && $stable(rd_a_idx)) |-> $stable(rd_a_data));

  // R4
  idle_b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && $stable(rd_b_idx)) |-> $stable(rd_b_data));
endmodule

bind gprf_bank_2r1w gprf_chk #(
  .DATA_W (DATA_W),
  .IDX_W  (IDX_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .wr_data   (wr_data),
  .rd_a_idx  (rd_a_idx),
  .rd_a_data (rd_a_data),
  .rd_b_idx  (rd_b_idx),
  .rd_b_data (rd_b_data)
);

// File: tb/gprf_bank_2r1w_tb_top.sv
module gprf_bank_2r1w_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 32;
  localparam int DW   = 32;
  localparam int IW   = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic [DW-1:0] wr_data;
  logic [IW-1:0] rd_a_idx;
  logic [IW-1:0] rd_b_idx;
  logic [DW-1:0] rd_a_data;
  logic [DW-1:0] rd_b_data;

  logic [DW-1:0] model [NREG];
  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gprf_bank_2r1w dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rd_a_idx  (rd_a_idx),
    .rd_a_data (rd_a_data),
    .rd_b_idx  (rd_b_idx),
    .rd_b_data (rd_b_data)
  );

  function automatic logic [DW-1:0] expect_rd(input logic [IW-1:0] idx);
    return (idx == 0 || !rst_n) ? '0 : model[idx];
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  task automatic check_ports(input string req);
    check(req, rd_a_data, expect_rd(rd_a_idx));
    check(req, rd_b_data, expect_rd(rd_b_idx));
  endtask

  // One clock cycle: drive, check old contents, falling-edge write, check new, move reads.
  task automatic cycle(input logic we, input logic [IW-1:0] wi, input logic [DW-1:0] wd,
                       input logic [IW-1:0] ra, input logic [IW-1:0] rb, input string req);
    @(posedge clk);
    #1;
    wr_en = we; wr_idx = wi; wr_data = wd; rd_a_idx = ra; rd_b_idx = rb;
    #2;
    check_ports({req, "/R8 before edge"});
    @(negedge clk);
    if (rst_n && we && wi != 0) model[wi] = wd;
    #2;
    check_ports({req, "/R3 after edge"});
    rd_a_idx = IW'($urandom);
    rd_b_idx = IW'($urandom);
    #1;
    check_ports("R5 index move");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual run still active, expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < NREG; i++) model[i] = '0;
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0; rd_a_idx = '0; rd_b_idx = '0;

    // R6: reset state, writes blocked during reset
    for (int i = 0; i < 4; i++) cycle(1'b1, IW'(i + 3), 32'hDEAD_0000 + DW'(i), IW'(i + 3), IW'(31 - i), "R6");
    cycle(1'b0, '0, '0, 5'd1, 5'd31, "R6");
    @(posedge clk); #1 rst_n = 1'b1;

    // R1: fill every entry with a distinct value, then read back all entries
    for (int i = 0; i < NREG; i++) cycle(1'b1, IW'(i), 32'hA5A5_0000 ^ (DW'(i) * 32'h0101_0101), IW'(i), IW'(NREG - 1 - i), "R1");
    for (int i = 0; i < NREG; i++) cycle(1'b0, IW'(i), 32'hFFFF_FFFF, IW'(i), IW'(NREG - 1 - i), "R1/R4");

    // R7: write to index 0 has no effect
    cycle(1'b1, 5'd0, 32'hFFFF_FFFF, 5'd0, 5'd0, "R7");
    for (int i = 0; i < NREG; i++) cycle(1'b0, '0, '0, IW'(i), 5'd0, "R7/R2");

    // R4: enable low with matching index and data present
    cycle(1'b0, 5'd9, 32'h1234_5678, 5'd9, 5'd9, "R4");

    // R8/R3: same-cycle read of the entry being written, on both ports
    cycle(1'b1, 5'd17, 32'hCAFE_F00D, 5'd17, 5'd17, "R8");
    cycle(1'b1, 5'd31, 32'h8000_0001, 5'd31, 5'd0, "R8/R2");

    // R5: ports read different entries in the same cycle
    cycle(1'b1, 5'd2, 32'h0BAD_BEEF, 5'd2, 5'd17, "R5");

    // Constrained random traffic; half the reads target the write index
    for (int n = 0; n < 400; n++) begin
      logic          we;
      logic [IW-1:0] wi;
      logic [IW-1:0] ra;
      logic [IW-1:0] rb;
      we = ($urandom % 4) != 0;
      wi = IW'($urandom);
      ra = ($urandom % 2) ? wi : IW'($urandom);
      rb = ($urandom % 2) ? wi : IW'($urandom);
      cycle(we, wi, $urandom, ra, rb, "R3/R5 random");
    end

    // R6: asynchronous reset in mid-run clears everything at once
    @(posedge clk); #3 rst_n = 1'b0;
    for (int i = 0; i < NREG; i++) model[i] = '0;
    #1 check_ports("R6 async clear");
    for (int i = 0; i < NREG; i++) cycle(1'b1, IW'(i), 32'h7777_7777, IW'(i), IW'(NREG - 1 - i), "R6");
    cycle(1'b0, '0, '0, '0, '0, "R6");
    @(posedge clk); #1 rst_n = 1'b1;
    cycle(1'b1, 5'd12, 32'h0000_00C3, 5'd12, 5'd13, "R3 after reset");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule